// File: doc/BRIEF.md
# Byte/Word Arithmetic and Logic Unit

This block is the combinational arithmetic/logic stage of a small 16-bit processor with an octal-friendly, two-operand instruction set. Each cycle it takes a destination operand (`opA`), a source operand (`opB`), an operation code, a byte-mode flag and the current negative, zero and carry flags. It returns the value to be written back, a write-enable, and the next values of the three flags. The branch unit uses these flags to test carry, sign and zero.

The unit covers several operation groups. The two-operand group has move, add and subtract with and without carry, compare and test. The logical group has AND, OR, XOR and NOT. The single-operand group has increment and decrement. The register group has single-bit shifts, rotates through carry, sign-extend of the low byte and duplication of the low byte. Two operations set and clear the carry explicitly.

In byte mode the unit works on the low byte only and takes its flags from that byte. Register-group operations always act on the full word. Compare and test update only the flags and never request a write.

Top module: `bw_alu`

## Requirements
- R1: `opSel` codes are 0 MOV, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 CMP, 6 TST, 7 AND, 8 OR, 9 XOR, 10 NOT, 11 INC, 12 DEC, 13 ASR, 14 LSL, 15 LSR, 16 RCL, 17 RCR, 18 SXB, 19 DUB, 20 SEC, 21 CLC. Every code from 0 to 19 other than 5 and 6 raises `writeEn`. MOV returns `opB`, and N and Z follow the value that is returned.
- R2: ADD returns opA+opB and SUB returns opA−opB, and both ignore `carryIn`. ADC adds `carryIn` as well. SBC also subtracts `carryIn` as a borrow.
- R3: CMP sets the flags as SUB would, and TST sets them as AND would. Both hold `writeEn` low.
- R4: After add-class operations, C is the carry out of the top bit of the active width. After subtract-class operations (SUB, SBC, CMP), C is 1 exactly when a borrow occurs.
- R5: With `byteMode`=1, N is result bit 7 and Z is set when bits 7:0 are all zero. C comes from bit 7.
- R6: A byte result keeps `opA[15:8]` in bits 15:8. The one exception is a byte MOV, which clears bits 15:8.
- R7: AND, OR, XOR, NOT and TST clear C. MOV leaves C unchanged.
- R8: INC returns opA+1 and DEC returns opA−1. Both update N and Z and pass `carryIn` through to C.
- R9: LSL shifts left and fills with 0. LSR shifts right and fills with 0. ASR shifts right and keeps the sign bit. In each case C is the bit shifted out.
- R10: RCL shifts left with `carryIn` entering bit 0. RCR shifts right with `carryIn` entering bit 15. In both, C is the bit shifted out.
- R11: SXB returns bit 7 copied through bits 15:8 above `opA[7:0]`. DUB returns `opA[7:0]` in both bytes. Both leave C unchanged. All register-group operations (ASR through DUB) ignore `byteMode`.
- R12: SEC sets C and CLC clears it. Both hold `writeEn` low and pass N and Z through unchanged.
- R13: Codes 22 to 31 hold `writeEn` low and pass all three flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 5 | Operation code |
| byteMode | input | 1 | 1 selects the low-byte form |
| opA | input | 16 | Destination operand / register operand |
| opB | input | 16 | Source operand |
| carryIn | input | 1 | Current carry flag |
| negIn | input | 1 | Current negative flag |
| zeroIn | input | 1 | Current zero flag |
| result | output | 16 | Value to write back |
| writeEn | output | 1 | 1 when `result` is to be stored |
| negOut | output | 1 | Next negative flag |
| zeroOut | output | 1 | Next zero flag |
| carryOut | output | 1 | Next carry flag |

## Verification
The adder is driven with operand pairs that overflow into the sign bit, wrap to zero and underflow. These patterns separate the carry-out from a borrow, and a used carry-in from an ignored one. Byte-mode runs put values in the high byte that differ from the result. These runs show whether flags come from bit 7 or bit 15, and whether the high byte is kept or cleared. Shift and rotate tests place ones at both ends of the word, with the carry set opposite to the bit shifted out, so that fill bits and carry sources are each visible. The flag-only codes and the unused codes are given flag inputs that a careless design would overwrite.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_MOV = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
    OP_SBC = 5'd4,  OP_CMP = 5'd5,  OP_TST = 5'd6,  OP_AND = 5'd7,
    OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_NOT = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_ASR = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15,
    OP_RCL = 5'd16, OP_RCR = 5'd17, OP_SXB = 5'd18, OP_DUB = 5'd19,
    OP_SEC = 5'd20, OP_CLC = 5'd21
  } op_e;

  localparam int OP_COUNT = 22;

  typedef enum logic [1:0] {UNIT_ADD, UNIT_LOGIC, UNIT_SHIFT, UNIT_NONE} unit_e;
  typedef enum logic [2:0] {LG_PASS, LG_AND, LG_OR, LG_XOR, LG_NOT} logic_e;
  typedef enum logic [2:0] {SH_ASR, SH_LSL, SH_LSR, SH_RCL, SH_RCR, SH_SXB, SH_DUB} shift_e;
  typedef enum logic [1:0] {CY_KEEP, CY_UNIT, CY_ZERO, CY_ONE} carry_e;

  typedef struct packed {
    unit_e  unit;
    logic_e logicSel;
    shift_e shiftSel;
    logic   subtract;
    logic   useCarry;
    logic   unitStep;
    carry_e carrySel;
    logic   setNz;
    logic   writeEn;
    logic   wordOnly;
    logic   zeroExt;
  } strobe_t;

endpackage

// File: rtl/bw_alu_ctrl.sv
module bw_alu_ctrl
  import bw_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output strobe_t         st
);

  op_e opCode;
  assign opCode = op_e'(opSel);

  always_comb begin
    st          = '0;
    st.unit     = UNIT_NONE;
    st.carrySel = CY_KEEP;
    case (opCode)
      OP_MOV: begin
        st.unit = UNIT_LOGIC; st.logicSel = LG_PASS;
        st.setNz = 1'b1; st.writeEn = 1'b1; st.zeroExt = 1'b1;
      end
      OP_ADD, OP_ADC: begin
        st.unit = UNIT_ADD; st.carrySel = CY_UNIT;
        st.useCarry = (opCode == OP_ADC);
        st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        st.unit = UNIT_ADD; st.carrySel = CY_UNIT; st.subtract = 1'b1;
        st.useCarry = (opCode == OP_SBC);
        st.setNz = 1'b1; st.writeEn = (opCode != OP_CMP);
      end
      OP_TST, OP_AND: begin
        st.unit = UNIT_LOGIC; st.logicSel = LG_AND; st.carrySel = CY_ZERO;
        st.setNz = 1'b1; st.writeEn = (opCode == OP_AND);
      end
      OP_OR: begin
        st.unit = UNIT_LOGIC; st.logicSel = LG_OR; st.carrySel = CY_ZERO;
        st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_XOR: begin
        st.unit = UNIT_LOGIC; st.logicSel = LG_XOR; st.carrySel = CY_ZERO;
        st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_NOT: begin
        st.unit = UNIT_LOGIC; st.logicSel = LG_NOT; st.carrySel = CY_ZERO;
        st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_INC, OP_DEC: begin
        st.unit = UNIT_ADD; st.unitStep = 1'b1;
        st.subtract = (opCode == OP_DEC);
        st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_ASR, OP_LSL, OP_LSR, OP_RCL, OP_RCR: begin
        st.unit = UNIT_SHIFT; st.carrySel = CY_UNIT;
        st.wordOnly = 1'b1; st.setNz = 1'b1; st.writeEn = 1'b1;
        case (opCode)
          OP_ASR:  st.shiftSel = SH_ASR;
          OP_LSL:  st.shiftSel = SH_LSL;
          OP_LSR:  st.shiftSel = SH_LSR;
          OP_RCL:  st.shiftSel = SH_RCL;
          default: st.shiftSel = SH_RCR;
        endcase
      end
      OP_SXB, OP_DUB: begin
        st.unit = UNIT_SHIFT;
        st.shiftSel = (opCode == OP_SXB) ? SH_SXB : SH_DUB;
        st.wordOnly = 1'b1; st.setNz = 1'b1; st.writeEn = 1'b1;
      end
      OP_SEC: st.carrySel = CY_ONE;
      OP_CLC: st.carrySel = CY_ZERO;
      default: ;
    endcase
  end

  always_comb begin
    if (opSel >= OP_W'(OP_COUNT)) begin
      AST_UNUSED_QUIET_CTRL: assert (!st.writeEn && !st.setNz && st.carrySel == CY_KEEP); // R13
    end
  end

endmodule

// File: rtl/bw_alu_dp.sv
module bw_alu_dp
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  strobe_t           st,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              negIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              negOut,
  output logic              zeroOut,
  output logic              carryOut
);

  localparam int HIGH_W = DATA_W - BYTE_W;
  localparam int LANES  = DATA_W / BYTE_W;

  logic              byteSel;
  logic [DATA_W-1:0] stepVal, bSel, bEff;
  logic              cinEff;
  logic [DATA_W:0]   sumWide;
  logic              addCarry;
  logic [DATA_W-1:0] logicRes, shiftRes, dupVal, rawRes;
  logic              shiftCarry, unitCarry, nCalc, zCalc;

  assign byteSel = byteMode && !st.wordOnly;

  // adder shared by add, subtract, compare, increment, decrement
  assign stepVal = {{(DATA_W-1){1'b0}}, 1'b1};
  assign bSel    = st.unitStep ? stepVal : opB;
  assign bEff    = st.subtract ? ~bSel : bSel;
  assign cinEff  = st.useCarry ? (carryIn ^ st.subtract) : st.subtract;
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cinEff};

  // carry into bit BYTE_W is the byte-width carry-out
  assign addCarry = (byteSel ? (opA[BYTE_W] ^ bEff[BYTE_W] ^ sumWide[BYTE_W])
                             : sumWide[DATA_W]) ^ st.subtract;

  always_comb begin
    case (st.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opA;
      default: logicRes = opB;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_dup
    assign dupVal[g*BYTE_W +: BYTE_W] = opA[BYTE_W-1:0];
  end

  always_comb begin
    shiftCarry = carryIn;
    case (st.shiftSel)
      SH_ASR: begin shiftRes = {opA[DATA_W-1], opA[DATA_W-1:1]}; shiftCarry = opA[0]; end
      SH_LSL: begin shiftRes = {opA[DATA_W-2:0], 1'b0};          shiftCarry = opA[DATA_W-1]; end
      SH_LSR: begin shiftRes = {1'b0, opA[DATA_W-1:1]};          shiftCarry = opA[0]; end
      SH_RCL: begin shiftRes = {opA[DATA_W-2:0], carryIn};       shiftCarry = opA[DATA_W-1]; end
      SH_RCR: begin shiftRes = {carryIn, opA[DATA_W-1:1]};       shiftCarry = opA[0]; end
      SH_SXB: shiftRes = {{HIGH_W{opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
      default: shiftRes = dupVal;
    endcase
  end

  always_comb begin
    case (st.unit)
      UNIT_ADD:   begin rawRes = sumWide[DATA_W-1:0]; unitCarry = addCarry; end
      UNIT_LOGIC: begin rawRes = logicRes;            unitCarry = 1'b0; end
      UNIT_SHIFT: begin rawRes = shiftRes;            unitCarry = shiftCarry; end
      default:    begin rawRes = opA;                 unitCarry = carryIn; end
    endcase
  end

  assign result = byteSel ? {(st.zeroExt ? {HIGH_W{1'b0}} : opA[DATA_W-1:BYTE_W]),
                             rawRes[BYTE_W-1:0]}
                          : rawRes;

  assign nCalc = byteSel ? rawRes[BYTE_W-1] : rawRes[DATA_W-1];
  assign zCalc = byteSel ? ~|rawRes[BYTE_W-1:0] : ~|rawRes;

  assign writeEn = st.writeEn;
  assign negOut  = st.setNz ? nCalc : negIn;
  assign zeroOut = st.setNz ? zCalc : zeroIn;

  always_comb begin
    case (st.carrySel)
      CY_UNIT: carryOut = unitCarry;
      CY_ZERO: carryOut = 1'b0;
      CY_ONE:  carryOut = 1'b1;
      default: carryOut = carryIn;
    endcase
  end

  always_comb begin
    if (byteMode && !st.wordOnly && !st.zeroExt && st.writeEn) begin
      AST_BYTE_HIGH_KEPT: assert (result[DATA_W-1:BYTE_W] == opA[DATA_W-1:BYTE_W]); // R6
    end
    if (byteMode && !st.wordOnly && st.setNz && st.writeEn) begin
      AST_BYTE_FLAGS: assert (zeroOut == (result[BYTE_W-1:0] == '0) && negOut == result[BYTE_W-1]); // R5
    end
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              negIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              negOut,
  output logic              zeroOut,
  output logic              carryOut
);

  strobe_t st;

  bw_alu_ctrl u_ctrl (
    .opSel (opSel),
    .st    (st)
  );

  bw_alu_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .st       (st),
    .byteMode (byteMode),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .negIn    (negIn),
    .zeroIn   (zeroIn),
    .result   (result),
    .writeEn  (writeEn),
    .negOut   (negOut),
    .zeroOut  (zeroOut),
    .carryOut (carryOut)
  );

  always_comb begin
    if (opSel == OP_CMP || opSel == OP_TST) begin
      AST_PROBE_NO_WRITE: assert (!writeEn); // R3
    end
    if (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR || opSel == OP_NOT || opSel == OP_TST) begin
      AST_LOGIC_CLEARS_C: assert (!carryOut); // R7
    end
    if (opSel == OP_INC || opSel == OP_DEC) begin
      AST_STEP_KEEPS_C: assert (carryOut == carryIn); // R8
    end
    if (opSel == OP_SEC || opSel == OP_CLC) begin
      AST_FLAG_OP_QUIET: assert (!writeEn && negOut == negIn && zeroOut == zeroIn); // R12
    end
    if (opSel >= OP_W'(OP_COUNT)) begin
      AST_UNUSED_QUIET: assert (!writeEn && negOut == negIn && zeroOut == zeroIn && carryOut == carryIn); // R13
    end
  end

endmodule

// File: tb/bw_alu_bench.sv
module bw_alu_bench;
  import bw_alu_pkg::*;

  logic        clk = 1'b0;
  logic [4:0]  opSel = '0;
  logic        byteMode = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0, negIn = 1'b0, zeroIn = 1'b0;
  logic [15:0] result;
  logic        writeEn, negOut, zeroOut, carryOut;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;  // 50 MHz

  bw_alu u_bw_alu (
    .opSel(opSel), .byteMode(byteMode), .opA(opA), .opB(opB),
    .carryIn(carryIn), .negIn(negIn), .zeroIn(zeroIn),
    .result(result), .writeEn(writeEn), .negOut(negOut),
    .zeroOut(zeroOut), .carryOut(carryOut)
  );

  task automatic drive(input logic [4:0] op, input logic bm, input logic [15:0] a,
                       input logic [15:0] b, input logic c, input logic n, input logic z);
    @(posedge clk);
    #1;
    opSel = op; byteMode = bm; opA = a; opB = b;
    carryIn = c; negIn = n; zeroIn = z;
    @(negedge clk);
  endtask

  // flags vector is {writeEn, N, Z, C}
  task automatic expect_out(input string tag, input logic chkRes, input logic [15:0] expRes,
                            input logic [3:0] expFlags);
    logic [3:0] got;
    got = {writeEn, negOut, zeroOut, carryOut};
    if (chkRes) begin
      compared++;
      if (result !== expRes) begin
        mismatched++;
        $display("FAIL %s result: actual %h expected %h", tag, result, expRes);
      end
    end
    compared++;
    if (got !== expFlags) begin
      mismatched++;
      $display("FAIL %s flags{we,n,z,c}: actual %b expected %b", tag, got, expFlags);
    end
  endtask

  task automatic t_baseline;
    drive(OP_MOV, 0, 16'h0000, 16'h0000, 0, 1, 0);
    expect_out("R1 idle move", 1, 16'h0000, 4'b1010);
    drive(OP_MOV, 0, 16'h1111, 16'h8421, 1, 0, 1);
    expect_out("R1 word move", 1, 16'h8421, 4'b1101);
  endtask

  task automatic t_add;
    drive(OP_ADD, 0, 16'h7FFF, 16'h0001, 1, 0, 0);
    expect_out("R2 add ignores cin", 1, 16'h8000, 4'b1100);
    drive(OP_ADD, 0, 16'hFFFF, 16'h0001, 0, 0, 0);
    expect_out("R4 add wrap carry", 1, 16'h0000, 4'b1011);
    drive(OP_ADC, 0, 16'h0001, 16'h0002, 1, 0, 0);
    expect_out("R2 adc uses cin", 1, 16'h0004, 4'b1000);
  endtask

  task automatic t_sub;
    drive(OP_SUB, 0, 16'h0005, 16'h0007, 1, 0, 0);
    expect_out("R4 sub borrow", 1, 16'hFFFE, 4'b1101);
    drive(OP_SUB, 0, 16'h0007, 16'h0005, 1, 0, 0);
    expect_out("R2 sub ignores cin", 1, 16'h0002, 4'b1000);
    drive(OP_SBC, 0, 16'h0007, 16'h0005, 1, 0, 0);
    expect_out("R2 sbc uses borrow", 1, 16'h0001, 4'b1000);
    drive(OP_SBC, 0, 16'h0000, 16'h0000, 1, 0, 0);
    expect_out("R4 sbc borrow chain", 1, 16'hFFFF, 4'b1101);
  endtask

  task automatic t_probe;
    drive(OP_CMP, 0, 16'h0003, 16'h0003, 1, 1, 0);
    expect_out("R3 cmp equal", 0, 16'h0, 4'b0010);
    drive(OP_CMP, 0, 16'h0002, 16'h0003, 0, 0, 1);
    expect_out("R3 cmp below", 0, 16'h0, 4'b0101);
    drive(OP_TST, 0, 16'hF0F0, 16'h0F0F, 1, 1, 0);
    expect_out("R3 tst disjoint", 0, 16'h0, 4'b0010);
  endtask

  task automatic t_byte;
    drive(OP_ADD, 1, 16'h12FF, 16'h3401, 0, 1, 0);
    expect_out("R5 byte add carry", 1, 16'h1200, 4'b1011);
    drive(OP_SUB, 1, 16'hAB00, 16'h0001, 0, 0, 1);
    expect_out("R6 byte sub keeps high", 1, 16'hABFF, 4'b1101);
    drive(OP_ADD, 1, 16'h00F0, 16'h0020, 0, 0, 0);
    expect_out("R5 byte flags from bit7", 1, 16'h0010, 4'b1001);
    drive(OP_MOV, 1, 16'hABCD, 16'h1280, 1, 0, 1);
    expect_out("R6 byte move zero-extends", 1, 16'h0080, 4'b1101);
  endtask

  task automatic t_logic;
    drive(OP_AND, 0, 16'h0F0F, 16'h00FF, 1, 1, 1);
    expect_out("R7 and clears C", 1, 16'h000F, 4'b1000);
    drive(OP_OR, 0, 16'h8000, 16'h0001, 1, 0, 0);
    expect_out("R7 or", 1, 16'h8001, 4'b1100);
    drive(OP_XOR, 0, 16'h5555, 16'h5555, 1, 1, 0);
    expect_out("R7 xor", 1, 16'h0000, 4'b1010);
    drive(OP_NOT, 0, 16'h00FF, 16'h0000, 1, 0, 0);
    expect_out("R7 not", 1, 16'hFF00, 4'b1100);
    drive(OP_NOT, 1, 16'h12FF, 16'h0000, 1, 1, 0);
    expect_out("R6 byte not", 1, 16'h1200, 4'b1010);
  endtask

  task automatic t_step;
    drive(OP_INC, 0, 16'hFFFF, 16'h1234, 0, 1, 0);
    expect_out("R8 inc wrap keeps C0", 1, 16'h0000, 4'b1010);
    drive(OP_INC, 0, 16'h7FFF, 16'h0000, 1, 0, 1);
    expect_out("R8 inc keeps C1", 1, 16'h8000, 4'b1101);
    drive(OP_DEC, 0, 16'h0000, 16'h0000, 0, 0, 1);
    expect_out("R8 dec wrap", 1, 16'hFFFF, 4'b1100);
    drive(OP_INC, 1, 16'h34FF, 16'h0000, 1, 0, 0);
    expect_out("R8 byte inc", 1, 16'h3400, 4'b1011);
  endtask

  task automatic t_shift;
    drive(OP_ASR, 0, 16'h8001, 16'h0, 0, 0, 0);
    expect_out("R9 asr", 1, 16'hC000, 4'b1101);
    drive(OP_LSL, 0, 16'h8001, 16'h0, 0, 1, 0);
    expect_out("R9 lsl", 1, 16'h0002, 4'b1001);
    drive(OP_LSR, 0, 16'h8001, 16'h0, 0, 1, 0);
    expect_out("R9 lsr", 1, 16'h4000, 4'b1001);
    drive(OP_LSR, 0, 16'h0002, 16'h0, 1, 0, 0);
    expect_out("R9 lsr carry clear", 1, 16'h0001, 4'b1000);
    drive(OP_LSL, 1, 16'h4080, 16'h0, 1, 0, 0);
    expect_out("R11 lsl ignores byteMode", 1, 16'h8100, 4'b1100);
  endtask

  task automatic t_rotate;
    drive(OP_RCL, 0, 16'h8000, 16'h0, 1, 0, 0);
    expect_out("R10 rcl", 1, 16'h0001, 4'b1001);
    drive(OP_RCR, 0, 16'h0001, 16'h0, 0, 1, 0);
    expect_out("R10 rcr out", 1, 16'h0000, 4'b1011);
    drive(OP_RCR, 0, 16'h0002, 16'h0, 1, 0, 0);
    expect_out("R10 rcr in", 1, 16'h8001, 4'b1100);
  endtask

  task automatic t_regs;
    drive(OP_SXB, 0, 16'h1280, 16'h0, 1, 0, 1);
    expect_out("R11 sxb negative", 1, 16'hFF80, 4'b1101);
    drive(OP_SXB, 1, 16'hFF7F, 16'h0, 0, 1, 0);
    expect_out("R11 sxb positive byteMode", 1, 16'h007F, 4'b1000);
    drive(OP_DUB, 0, 16'h00A5, 16'h0, 1, 0, 1);
    expect_out("R11 dub", 1, 16'hA5A5, 4'b1101);
    drive(OP_DUB, 1, 16'h1200, 16'h0, 0, 1, 0);
    expect_out("R11 dub zero byteMode", 1, 16'h0000, 4'b1010);
  endtask

  task automatic t_carry_ops;
    drive(OP_SEC, 0, 16'h0000, 16'h0000, 0, 1, 0);
    expect_out("R12 sec", 0, 16'h0, 4'b0101);
    drive(OP_CLC, 0, 16'hFFFF, 16'hFFFF, 1, 0, 1);
    expect_out("R12 clc", 0, 16'h0, 4'b0010);
  endtask

  task automatic t_unused;
    drive(5'd25, 0, 16'h0000, 16'h0001, 1, 1, 1);
    expect_out("R13 code 25", 0, 16'h0, 4'b0111);
    drive(5'd31, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1);
    expect_out("R13 code 31", 0, 16'h0, 4'b0010);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_baseline();
    t_add();
    t_sub();
    t_probe();
    t_byte();
    t_logic();
    t_step();
    t_shift();
    t_rotate();
    t_regs();
    t_carry_ops();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule